// File: doc/BRIEF.md
# Search Result Latency Pipeline

This block sits behind the match engine of a cascaded lookup table. Each search command brings a winning address and a hit flag. The block holds them in a fixed-depth pipeline and presents them to the external SRAM interface in a later access cycle. That cycle comes a configurable number of cycles after the command.

The command-to-access delay depends on how many devices make up the table. A two-bit size code selects it. A separate three-bit field delays the two status strobes (result valid and result found) by a further 0 to 7 cycles after the address. The valid strobe marks every finished search. The found strobe marks only searches that hit.

The arbitration on the shared result bus is reduced to a single driver enable. A device raises it in the access cycle when it holds the hit. On a miss, it raises it only if it is set up as the final device of the table and of the chain. Commands may arrive as often as every cycle, and results leave in the order the commands were issued.

Top module: `srch_result_pipe`

## Requirements
- R1: With size code 2'b00, the access cycle (`sram_ce_n` and `sram_ale_n` low for one cycle, `sram_addr` equal to the winning address) comes 4 cycles after the cycle in which `cmd_vld` is sampled high.
- R2: With size code 2'b01, the access cycle comes 5 cycles after the command.
- R3: With size code 2'b10, the access cycle comes 6 cycles after the command. The reserved code 2'b11 behaves the same way.
- R4: `res_valid` is high for exactly one cycle per command. That cycle comes H cycles after the access cycle, where H is the unsigned value of `cfg_hit_lat` (0 to 7).
- R5: `res_found` is high in the `res_valid` cycle of a command issued with `win_hit` = 1. It is low at all other times, including for misses.
- R6: `sram_we_n` is always high (read). Outside an access cycle, `sram_ce_n` and `sram_ale_n` are high and `sram_addr` is zero.
- R7: `bus_drv_en` is high in an access cycle when that search hit, or when it missed and `cfg_last_dev` = 1. It is low otherwise.
- R8: Commands issued every cycle or every few cycles each produce exactly one result. Results come out in issue order and carry their own address.
- R9: While reset is held and right after it, all strobes are inactive, `bus_drv_en` is low and `sram_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Search command issued this cycle |
| win_addr | input | ADDR_W (22) | Winning address of the search |
| win_hit | input | 1 | Search found a matching entry |
| cfg_tbl_size | input | 2 | Table-size code selecting the base latency |
| cfg_hit_lat | input | HLAT_W (3) | Extra status-strobe delay in cycles |
| cfg_last_dev | input | 1 | Device is last in table and chain (drives on miss) |
| sram_addr | output | ADDR_W (22) | SRAM address in the access cycle |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ale_n | output | 1 | Address latch enable, active low |
| sram_we_n | output | 1 | Write enable, held high |
| res_valid | output | 1 | Search-valid strobe |
| res_found | output | 1 | Search-found strobe |
| bus_drv_en | output | 1 | Result bus driver enable |

## Verification
The latency assertions assume that `cfg_tbl_size` and `cfg_hit_lat` stay constant while any command is still inside the pipeline. A change in flight would move the tap under an entry and could drop or repeat it. The stimulus therefore changes the configuration only after an idle gap longer than the deepest path (13 cycles). It then sweeps every size code, every strobe delay and both driver settings, issuing bursts at spacings of one to three cycles with mixed hits and misses.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic [1:0] {
      TSZ_ONE   = 2'b00,
      TSZ_EIGHT = 2'b01,
      TSZ_FULL  = 2'b10,
      TSZ_RSVD  = 2'b11
   } tsize_e;

   typedef struct packed {
      logic act;
      logic hit;
   } ctl_t;

endpackage

// File: rtl/srp_delay_line.sv
module srp_delay_line #(
   parameter int W     = 2,
   parameter int DEPTH = 4,
   parameter bit CLR   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [W-1:0]               d,
   output logic [DEPTH:1][W-1:0]      taps
);

   if (DEPTH < 2) begin : g_bad_depth
      initial $fatal(1, "srp_delay_line: DEPTH must be at least 2");
   end

   for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
      logic [W-1:0] nxt;
      if (i == 1) begin : g_head
         assign nxt = d;
      end else begin : g_body
         assign nxt = taps[i-1];
      end

      if (CLR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps[i] <= '0;
            else        taps[i] <= nxt;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            taps[i] <= nxt;
         end
      end
   end

endmodule

// File: rtl/srp_tap_mux.sv
module srp_tap_mux #(
   parameter int W     = 2,
   parameter int DEPTH = 4,
   parameter int SEL_W = 3
) (
   input  logic [DEPTH:1][W-1:0] taps,
   input  logic [SEL_W-1:0]      sel,
   output logic [W-1:0]          q
);

   if ((1 << SEL_W) <= DEPTH) begin : g_bad_sel
      initial $fatal(1, "srp_tap_mux: SEL_W too narrow for DEPTH");
   end

   always_comb begin
      q = '0;
      for (int i = 1; i <= DEPTH; i++) begin
         if (sel == SEL_W'(i)) q = taps[i];
      end
   end

endmodule

// File: rtl/srch_result_pipe.sv
module srch_result_pipe
   import srp_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int LAT_ONE     = 4,
   parameter int LAT_EIGHT   = 5,
   parameter int LAT_FULL    = 6,
   parameter int HLAT_W      = 3,
   parameter bit CLR_PAYLOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [ADDR_W-1:0] win_addr,
   input  logic              win_hit,
   input  logic [1:0]        cfg_tbl_size,
   input  logic [HLAT_W-1:0] cfg_hit_lat,
   input  logic              cfg_last_dev,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_ale_n,
   output logic              sram_we_n,
   output logic              res_valid,
   output logic              res_found,
   output logic              bus_drv_en
);

   localparam int MAX_HL    = (1 << HLAT_W) - 1;
   localparam int ADR_DEPTH = LAT_FULL - 1;
   localparam int CTL_DEPTH = LAT_FULL - 1 + MAX_HL;
   localparam int SEL_W     = $clog2(CTL_DEPTH + 2);
   localparam int CTL_W     = $bits(ctl_t);

   if (LAT_ONE < 3 || LAT_EIGHT < LAT_ONE || LAT_FULL < LAT_EIGHT) begin : g_bad_lat
      initial $fatal(1, "srch_result_pipe: latencies must be >= 3 and non-decreasing");
   end
   if (ADDR_W < 1 || HLAT_W < 1) begin : g_bad_w
      initial $fatal(1, "srch_result_pipe: widths must be positive");
   end

   // command entry
   ctl_t ctl_in;
   assign ctl_in.act = cmd_vld;
   assign ctl_in.hit = cmd_vld & win_hit;

   // tap selection from configuration
   logic [SEL_W-1:0] base_tap;
   logic [SEL_W-1:0] stb_tap;

   always_comb begin
      case (tsize_e'(cfg_tbl_size))
         TSZ_ONE:   base_tap = SEL_W'(LAT_ONE - 1);
         TSZ_EIGHT: base_tap = SEL_W'(LAT_EIGHT - 1);
         default:   base_tap = SEL_W'(LAT_FULL - 1);
      endcase
   end
   assign stb_tap = base_tap + SEL_W'(cfg_hit_lat);

   // shared control line, deep enough for the longest strobe path
   logic [CTL_DEPTH:1][CTL_W-1:0] ctl_taps;
   srp_delay_line #(.W(CTL_W), .DEPTH(CTL_DEPTH), .CLR(1'b1)) i_ctl_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_in),
      .taps  (ctl_taps)
   );

   // address line, only as deep as the longest base latency
   logic [ADR_DEPTH:1][ADDR_W-1:0] adr_taps;
   srp_delay_line #(.W(ADDR_W), .DEPTH(ADR_DEPTH), .CLR(CLR_PAYLOAD)) i_adr_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (win_addr),
      .taps  (adr_taps)
   );

   logic [CTL_W-1:0]  base_ctl_raw;
   logic [CTL_W-1:0]  stb_ctl_raw;
   logic [ADDR_W-1:0] base_addr;
   ctl_t              base_ctl;
   ctl_t              stb_ctl;

   srp_tap_mux #(.W(CTL_W), .DEPTH(CTL_DEPTH), .SEL_W(SEL_W)) i_base_ctl_mux (
      .taps (ctl_taps),
      .sel  (base_tap),
      .q    (base_ctl_raw)
   );

   srp_tap_mux #(.W(CTL_W), .DEPTH(CTL_DEPTH), .SEL_W(SEL_W)) i_stb_ctl_mux (
      .taps (ctl_taps),
      .sel  (stb_tap),
      .q    (stb_ctl_raw)
   );

   srp_tap_mux #(.W(ADDR_W), .DEPTH(ADR_DEPTH), .SEL_W(SEL_W)) i_adr_mux (
      .taps (adr_taps),
      .sel  (base_tap),
      .q    (base_addr)
   );

   assign base_ctl = ctl_t'(base_ctl_raw);
   assign stb_ctl  = ctl_t'(stb_ctl_raw);

   // output stage
   logic              acc_act;
   logic [ADDR_W-1:0] acc_addr;
   logic              drv_q;
   logic              stb_v;
   logic              stb_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_act  <= 1'b0;
         acc_addr <= '0;
         drv_q    <= 1'b0;
         stb_v    <= 1'b0;
         stb_f    <= 1'b0;
      end else begin
         acc_act  <= base_ctl.act;
         acc_addr <= base_ctl.act ? base_addr : '0;
         drv_q    <= base_ctl.act & (base_ctl.hit | cfg_last_dev);
         stb_v    <= stb_ctl.act;
         stb_f    <= stb_ctl.act & stb_ctl.hit;
      end
   end

   assign sram_addr  = acc_addr;
   assign sram_ce_n  = ~acc_act;
   assign sram_ale_n = ~acc_act;
   assign sram_we_n  = 1'b1;
   assign res_valid  = stb_v;
   assign res_found  = stb_f;
   assign bus_drv_en = drv_q;

   // checking state: independent history of issued commands
   logic [CTL_DEPTH+1:1] chk_cmd;
   logic [CTL_DEPTH+1:1] chk_hit;
   int                   chk_base;
   int                   chk_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_cmd <= '0;
         chk_hit <= '0;
      end else begin
         chk_cmd <= {chk_cmd[CTL_DEPTH:1], cmd_vld};
         chk_hit <= {chk_hit[CTL_DEPTH:1], cmd_vld & win_hit};
      end
   end

   always_comb begin
      case (cfg_tbl_size)
         2'b00:   chk_base = LAT_ONE;
         2'b01:   chk_base = LAT_EIGHT;
         default: chk_base = LAT_FULL;
      endcase
      chk_stb = chk_base + int'(cfg_hit_lat);
   end

   AST_ACCESS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n) == chk_cmd[chk_base]);  // R1, R2, R3

   AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == chk_cmd[chk_stb]);  // R4

   AST_FOUND_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_found |-> res_valid);  // R5

   AST_FOUND_MATCHES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_found == chk_hit[chk_stb]));  // R5

   AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce_n |-> (sram_addr == '0));  // R6

   AST_LATCH_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ale_n == sram_ce_n);  // R6

   AST_DRIVE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drv_en |-> !sram_ce_n);  // R7

endmodule

// File: tb/test_srch_result_pipe.sv
module test_srch_result_pipe;

   localparam int AW = 22;
   localparam int NREC = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_vld = 1'b0;
   logic [AW-1:0] win_addr = '0;
   logic          win_hit = 1'b0;
   logic [1:0]    cfg_tbl_size = 2'b00;
   logic [2:0]    cfg_hit_lat = 3'd0;
   logic          cfg_last_dev = 1'b0;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_ale_n, sram_we_n;
   logic          res_valid, res_found, bus_drv_en;

   always #5 clk = ~clk;

   srch_result_pipe i_srch_result_pipe (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_vld      (cmd_vld),
      .win_addr     (win_addr),
      .win_hit      (win_hit),
      .cfg_tbl_size (cfg_tbl_size),
      .cfg_hit_lat  (cfg_hit_lat),
      .cfg_last_dev (cfg_last_dev),
      .sram_addr    (sram_addr),
      .sram_ce_n    (sram_ce_n),
      .sram_ale_n   (sram_ale_n),
      .sram_we_n    (sram_we_n),
      .res_valid    (res_valid),
      .res_found    (res_found),
      .bus_drv_en   (bus_drv_en)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   bit            iss_v [0:NREC-1];
   bit            iss_h [0:NREC-1];
   logic [AW-1:0] iss_a [0:NREC-1];

   int n_chk = 0;
   int n_bad = 0;
   int n_issued = 0;
   int n_valid = 0;
   logic [AW-1:0] last_seen_addr;

   task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   function automatic int base_lat(input logic [1:0] ts);
      return (ts == 2'b00) ? 4 : (ts == 2'b01) ? 5 : 6;
   endfunction

   // compare all outputs against the issue record, then drive the next cycle
   task automatic step(input bit v, input logic [AW-1:0] a, input bit h);
      int m, l, hl, ka, ks;
      bit ea, es, ef, ed;
      logic [AW-1:0] exa;
      string ltag;
      @(negedge clk);
      m  = cyc;
      l  = base_lat(cfg_tbl_size);
      hl = int'(cfg_hit_lat);
      ka = m - l;
      ks = m - l - hl;
      ea = (ka >= 0 && ka < NREC) ? iss_v[ka] : 1'b0;
      es = (ks >= 0 && ks < NREC) ? iss_v[ks] : 1'b0;
      ef = es && iss_h[ks];
      ed = ea && (iss_h[ka] || cfg_last_dev);
      exa = ea ? iss_a[ka] : '0;
      ltag = (l == 4) ? "R1" : (l == 5) ? "R2" : "R3";
      chk(ltag, (!sram_ce_n) == ea, 32'(!sram_ce_n), 32'(ea));
      chk(ltag, (!sram_ale_n) == ea, 32'(!sram_ale_n), 32'(ea));
      chk(ea ? ltag : "R6", sram_addr == exa, 32'(sram_addr), 32'(exa));
      chk("R6", sram_we_n == 1'b1, 32'(sram_we_n), 32'd1);
      chk("R4", res_valid == es, 32'(res_valid), 32'(es));
      chk("R5", res_found == ef, 32'(res_found), 32'(ef));
      chk("R7", bus_drv_en == ed, 32'(bus_drv_en), 32'(ed));
      if (res_valid) n_valid++;
      if (!sram_ce_n) last_seen_addr = sram_addr;
      cmd_vld  = v;
      win_addr = a;
      win_hit  = h;
      if (cyc < NREC) begin
         iss_v[cyc] = v;
         iss_h[cyc] = v & h;
         iss_a[cyc] = a;
      end
      if (v) n_issued++;
   endtask

   initial begin
      for (int i = 0; i < NREC; i++) begin
         iss_v[i] = 1'b0;
         iss_h[i] = 1'b0;
         iss_a[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R9: state while reset is held
      chk("R9", sram_ce_n && sram_ale_n, 32'({sram_ce_n, sram_ale_n}), 32'd3);
      chk("R9", !res_valid && !res_found && !bus_drv_en,
          32'({res_valid, res_found, bus_drv_en}), 32'd0);
      chk("R9", sram_addr == '0, 32'(sram_addr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", sram_ce_n && !res_valid && !bus_drv_en,
          32'({sram_ce_n, res_valid, bus_drv_en}), 32'd4);

      for (int ts = 0; ts < 4; ts++) begin
         for (int hl = 0; hl < 8; hl++) begin
            for (int ld = 0; ld < 2; ld++) begin
               int sp, idx;
               logic [AW-1:0] first_a, final_a;
               @(negedge clk);
               cfg_tbl_size = 2'(ts);
               cfg_hit_lat  = 3'(hl);
               cfg_last_dev = 1'(ld);
               sp  = ((ts + hl + ld) % 3) + 1;
               idx = ts * 16 + hl * 2 + ld;
               n_issued = 0;
               n_valid  = 0;
               first_a = '0;
               final_a = '0;
               for (int n = 0; n < 6; n++) begin
                  logic [AW-1:0] a;
                  a = AW'((idx * 40961 + n * 131071 + 7) ^ 32'h2A5A5);
                  if (n == 0) first_a = a;
                  final_a = a;
                  step(1'b1, a, ((n + hl) % 3) != 0);
                  for (int g = 1; g < sp; g++) step(1'b0, '0, 1'b1);
               end
               for (int g = 0; g < 16; g++) step(1'b0, '0, 1'b0);
               // R8: every command produced exactly one result, in order
               chk(sp == 1 ? "R8 back-to-back" : "R8", n_valid == n_issued,
                   32'(n_valid), 32'(n_issued));
               chk("R8", last_seen_addr == final_a, 32'(last_seen_addr), 32'(final_a));
               if (first_a == final_a) chk("R8", 1'b0, 32'(first_a), 32'(final_a));
            end
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule